// File: doc/BRIEF.md
# Register In-Use Scoreboard

This block keeps one in-use flag for each entry of a 32-entry general register file. It tells the issue stage whether the instruction now waiting may start. A flag goes up when an instruction that will later write that register is started. It drops when the write-back for that register completes. Write-backs arrive on two independent ports: an integer path and a longer-latency path. Both may retire in the same cycle.

The candidate instruction presents two source register numbers, a destination register number, a write-enable and a load marker. The block answers combinationally with `issue_ok`. That signal is low whenever a source register is still pending, or whenever the destination is pending and the candidate writes it. Register zero is hard-wired to zero, so it is never marked. A value coming back from a load stays guarded for one cycle after its write-back, so the instruction right behind the load cannot use it yet. A flush input drops every pending flag at once.

Top module: `reg_busy_track`

## Requirements
- R1: After reset, no register is marked, so `issue_ok` is 1 for any candidate.
- R2: A candidate starts when `cand_valid` and `issue_ok` are both 1. If it also has `cand_wen` = 1 and a non-zero `cand_dst`, that register is marked from the next cycle on.
- R3: When the register named by `cand_src_a` or by `cand_src_b` is marked, `issue_ok` is 0.
- R4: When `cand_dst` is marked, `issue_ok` is 0 if `cand_wen` = 1. With `cand_wen` = 0 the marked destination does not stall.
- R5: Register 0 is never marked, even when a candidate writes it, so it never stalls a candidate.
- R6: A write-back on either port (`wb_int_*` or `wb_long_*`) to a marked register that was not started as a load unmarks it from the next cycle. The two ports may unmark two different registers in the same cycle.
- R7: A register started with `cand_is_load` = 1 stays marked for the cycle after its write-back, and is unmarked from the cycle after that.
- R8: `flush` = 1 unmarks every register from the next cycle, and a start in the same cycle marks nothing.
- R9: `issue_ok` follows the candidate fields and the current marks within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Unmark every register |
| cand_valid | input | 1 | Candidate instruction present |
| cand_src_a | input | 5 | First source register number |
| cand_src_b | input | 5 | Second source register number |
| cand_dst | input | 5 | Destination register number |
| cand_wen | input | 1 | Candidate writes `cand_dst` |
| cand_is_load | input | 1 | Candidate is a load |
| wb_int_en | input | 1 | Integer-path write-back completes |
| wb_int_reg | input | 5 | Register retired on the integer path |
| wb_long_en | input | 1 | Long-latency write-back completes |
| wb_long_reg | input | 5 | Register retired on the long path |
| issue_ok | output | 1 | Candidate may start this cycle |

## Verification
Directed sequences cover several hazard types. A pending register is hit through source A alone, through source B alone, and through the destination with and without a write-enable, which separates the read check from the write check. A load and a plain write are retired on the same port, and the resulting stall windows differ by exactly one cycle. Two registers retire together on both ports, a write to register zero is followed by a read of it, and a flush is issued with several registers pending. A long pseudo-random phase with small register numbers then produces dense overlapping hazards, lingering loads and flushes, and every cycle of it is compared against a behavioural model.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  localparam int RBT_NUM_REGS = 32;
  localparam int RBT_IDX_W    = $clog2(RBT_NUM_REGS);
endpackage

// File: rtl/rbt_onehot_dec.sv
module rbt_onehot_dec #(
  parameter int NUM_REGS = rbt_pkg::RBT_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter bit SKIP_ZERO = 1'b1
) (
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] vec
);
  // One line per register; the hard-wired zero register is left out when asked.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_line
    if (SKIP_ZERO && g == 0) begin : g_zero
      assign vec[g] = 1'b0;
    end else begin : g_hit
      assign vec[g] = en && (idx == IDX_W'(g));
    end
  end
endmodule

// File: rtl/rbt_busy_bank.sv
module rbt_busy_bank #(
  parameter int NUM_REGS = rbt_pkg::RBT_NUM_REGS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [NUM_REGS-1:0] set_vec,
  input  logic                set_is_load,
  input  logic [NUM_REGS-1:0] hit_vec,
  output logic [NUM_REGS-1:0] busy_q,
  output logic [NUM_REGS-1:0] tag_q,
  output logic [NUM_REGS-1:0] linger_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    logic retire_now;
    logic start_linger;

    // Plain write-backs and expiring load holds both release the register.
    assign retire_now   = linger_q[g] | (hit_vec[g] & busy_q[g] & ~tag_q[g]);
    assign start_linger = hit_vec[g] & busy_q[g] & tag_q[g] & ~linger_q[g] & ~set_vec[g];

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        busy_q[g]   <= 1'b0;
        tag_q[g]    <= 1'b0;
        linger_q[g] <= 1'b0;
      end else begin
        // A new start on the register wins over any release.
        busy_q[g]   <= set_vec[g] | (busy_q[g] & ~retire_now);
        linger_q[g] <= start_linger;
        if (set_vec[g]) tag_q[g] <= set_is_load;
      end
    end
  end

  p_zero_never_busy_r5: assert property (@(posedge clk) disable iff (rst)
    !busy_q[0]);

  p_linger_implies_busy_r7: assert property (@(posedge clk) disable iff (rst)
    linger_q[NUM_REGS-1:0] == (linger_q & busy_q));
endmodule

// File: rtl/rbt_hazard.sv
module rbt_hazard #(
  parameter int NUM_REGS = rbt_pkg::RBT_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] busy,
  input  logic [IDX_W-1:0]    src_a,
  input  logic [IDX_W-1:0]    src_b,
  input  logic [IDX_W-1:0]    dst,
  input  logic                wen,
  output logic                ok
);
  logic raw_a, raw_b, waw;

  always_comb begin
    raw_a = busy[src_a];
    raw_b = busy[src_b];
    waw   = wen & busy[dst];
    ok    = ~(raw_a | raw_b | waw);
  end
endmodule

// File: rtl/reg_busy_track.sv
module reg_busy_track #(
  parameter int NUM_REGS = rbt_pkg::RBT_NUM_REGS,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             cand_valid,
  input  logic [IDX_W-1:0] cand_src_a,
  input  logic [IDX_W-1:0] cand_src_b,
  input  logic [IDX_W-1:0] cand_dst,
  input  logic             cand_wen,
  input  logic             cand_is_load,
  input  logic             wb_int_en,
  input  logic [IDX_W-1:0] wb_int_reg,
  input  logic             wb_long_en,
  input  logic [IDX_W-1:0] wb_long_reg,
  output logic             issue_ok
);
  logic [NUM_REGS-1:0] busy_q, tag_q, linger_q;
  logic [NUM_REGS-1:0] set_vec, wb_int_vec, wb_long_vec, hit_vec;
  logic                start_write;

  assign start_write = cand_valid & issue_ok & cand_wen;
  assign hit_vec     = wb_int_vec | wb_long_vec;

  rbt_onehot_dec #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SKIP_ZERO(1'b1)) i_set_dec (
    .en(start_write), .idx(cand_dst), .vec(set_vec)
  );
  rbt_onehot_dec #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SKIP_ZERO(1'b1)) i_int_dec (
    .en(wb_int_en), .idx(wb_int_reg), .vec(wb_int_vec)
  );
  rbt_onehot_dec #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SKIP_ZERO(1'b1)) i_long_dec (
    .en(wb_long_en), .idx(wb_long_reg), .vec(wb_long_vec)
  );

  rbt_busy_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk(clk), .rst(rst), .flush(flush),
    .set_vec(set_vec), .set_is_load(cand_is_load), .hit_vec(hit_vec),
    .busy_q(busy_q), .tag_q(tag_q), .linger_q(linger_q)
  );

  rbt_hazard #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_hazard (
    .busy(busy_q), .src_a(cand_src_a), .src_b(cand_src_b),
    .dst(cand_dst), .wen(cand_wen), .ok(issue_ok)
  );

  p_issue_marks_r2: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && issue_ok && cand_wen && cand_dst != '0 && !flush)
    |=> busy_q[$past(cand_dst)]);

  p_src_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q[cand_src_a] || busy_q[cand_src_b]) |-> !issue_ok);

  p_int_wb_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (wb_int_en && wb_int_reg != '0 && busy_q[wb_int_reg] && !tag_q[wb_int_reg]
     && !set_vec[wb_int_reg] && !flush)
    |=> !busy_q[$past(wb_int_reg)]);

  p_load_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_int_en && wb_int_reg != '0 && busy_q[wb_int_reg] && tag_q[wb_int_reg]
     && !linger_q[wb_int_reg] && !flush)
    |=> busy_q[$past(wb_int_reg)]);

  p_flush_all_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> busy_q == '0);
endmodule

// File: tb/test_reg_busy_track.sv
module test_reg_busy_track;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       cand_valid = 1'b0;
  logic [4:0] cand_src_a = '0, cand_src_b = '0, cand_dst = '0;
  logic       cand_wen = 1'b0, cand_is_load = 1'b0;
  logic       wb_int_en = 1'b0, wb_long_en = 1'b0;
  logic [4:0] wb_int_reg = '0, wb_long_reg = '0;
  logic       issue_ok;

  int errors = 0;
  int checks = 0;
  bit mb[32];
  bit mt[32];
  bit ml[32];

  always #10 clk = ~clk;

  reg_busy_track i_reg_busy_track (
    .clk(clk), .rst(rst), .flush(flush), .cand_valid(cand_valid),
    .cand_src_a(cand_src_a), .cand_src_b(cand_src_b), .cand_dst(cand_dst),
    .cand_wen(cand_wen), .cand_is_load(cand_is_load),
    .wb_int_en(wb_int_en), .wb_int_reg(wb_int_reg),
    .wb_long_en(wb_long_en), .wb_long_reg(wb_long_reg),
    .issue_ok(issue_ok)
  );

  function automatic bit model_ok();
    return !(mb[cand_src_a] || mb[cand_src_b] || (cand_wen && mb[cand_dst]));
  endfunction

  task automatic model_clock(input bit ok_now);
    bit nb[32];
    bit nt[32];
    bit nl[32];
    for (int r = 0; r < 32; r++) begin nb[r] = mb[r]; nt[r] = mt[r]; nl[r] = ml[r]; end
    if (flush) begin
      for (int r = 0; r < 32; r++) begin nb[r] = 0; nt[r] = 0; nl[r] = 0; end
    end else begin
      for (int r = 0; r < 32; r++) if (ml[r]) begin nb[r] = 0; nl[r] = 0; end
      if (wb_int_en && wb_int_reg != 0 && mb[wb_int_reg] && !ml[wb_int_reg]) begin
        if (mt[wb_int_reg]) nl[wb_int_reg] = 1; else nb[wb_int_reg] = 0;
      end
      if (wb_long_en && wb_long_reg != 0 && mb[wb_long_reg] && !ml[wb_long_reg]) begin
        if (mt[wb_long_reg]) nl[wb_long_reg] = 1; else nb[wb_long_reg] = 0;
      end
      if (cand_valid && ok_now && cand_wen && cand_dst != 0) begin
        nb[cand_dst] = 1; nt[cand_dst] = cand_is_load; nl[cand_dst] = 0;
      end
    end
    for (int r = 0; r < 32; r++) begin mb[r] = nb[r]; mt[r] = nt[r]; ml[r] = nl[r]; end
  endtask

  // Inputs are already set (after a falling edge); check mid-cycle, then clock the model.
  task automatic step(input string req);
    bit exp_ok;
    #5;
    exp_ok = model_ok();
    checks++;
    if (issue_ok !== exp_ok) begin
      errors++;
      $display("FAIL %s: issue_ok=%0b expected=%0b (a=%0d b=%0d d=%0d wen=%0b)",
               req, issue_ok, exp_ok, cand_src_a, cand_src_b, cand_dst, cand_wen);
    end
    @(posedge clk);
    model_clock(exp_ok);
    @(negedge clk);
    flush = 0; cand_valid = 0; cand_wen = 0; cand_is_load = 0;
    wb_int_en = 0; wb_long_en = 0;
    cand_src_a = 0; cand_src_b = 0; cand_dst = 0;
  endtask

  task automatic cand(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                      input bit wen, input bit ld);
    cand_valid = 1; cand_src_a = a; cand_src_b = b; cand_dst = d;
    cand_wen = wen; cand_is_load = ld;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin mb[r] = 0; mt[r] = 0; ml[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state, everything free
    cand(5'd9, 5'd17, 5'd31, 1, 0); cand_valid = 0; step("R1");
    // R2: start a write to r5
    cand(5'd1, 5'd2, 5'd5, 1, 0); step("R2 R9");
    // R3: source A and source B hit r5
    cand(5'd5, 5'd0, 5'd6, 0, 0); cand_valid = 0; step("R3");
    cand(5'd0, 5'd5, 5'd6, 0, 0); cand_valid = 0; step("R3");
    // R4: destination hit with and without write-enable
    cand(5'd1, 5'd2, 5'd5, 1, 0); cand_valid = 0; step("R4");
    cand(5'd1, 5'd2, 5'd5, 0, 0); cand_valid = 0; step("R4");
    // R6: integer write-back frees r5 next cycle
    wb_int_en = 1; wb_int_reg = 5'd5; cand(5'd5, 5'd0, 5'd0, 0, 0); cand_valid = 0; step("R6 R9");
    cand(5'd5, 5'd0, 5'd0, 0, 0); cand_valid = 0; step("R6");
    // R7: load to r7 lingers one cycle after write-back
    cand(5'd0, 5'd0, 5'd7, 1, 1); step("R7");
    wb_int_en = 1; wb_int_reg = 5'd7; cand(5'd7, 5'd0, 5'd0, 0, 0); cand_valid = 0; step("R7");
    cand(5'd7, 5'd0, 5'd0, 0, 0); cand_valid = 0; step("R7");
    cand(5'd7, 5'd0, 5'd0, 0, 0); cand_valid = 0; step("R7");
    // R6: two registers retire together
    cand(5'd0, 5'd0, 5'd3, 1, 0); step("R6");
    cand(5'd0, 5'd0, 5'd4, 1, 0); step("R6");
    cand(5'd3, 5'd4, 5'd0, 0, 0); cand_valid = 0; step("R6");
    wb_int_en = 1; wb_int_reg = 5'd3; wb_long_en = 1; wb_long_reg = 5'd4; step("R6");
    cand(5'd3, 5'd4, 5'd0, 0, 0); cand_valid = 0; step("R6");
    // R5: a write to r0 marks nothing
    cand(5'd0, 5'd0, 5'd0, 1, 1); step("R5");
    cand(5'd0, 5'd0, 5'd0, 1, 0); cand_valid = 0; step("R5");
    // R8: flush with several pending, plus a start in the flush cycle
    cand(5'd0, 5'd0, 5'd10, 1, 0); step("R8");
    cand(5'd0, 5'd0, 5'd11, 1, 1); step("R8");
    flush = 1; cand(5'd0, 5'd0, 5'd12, 1, 0); step("R8");
    cand(5'd10, 5'd11, 5'd12, 1, 0); cand_valid = 0; step("R8");

    // Mixed traffic: R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < 600; i++) begin
      cand(5'($urandom_range(7)), 5'($urandom_range(7)), 5'($urandom_range(7)),
           bit'($urandom_range(1)), bit'($urandom_range(1)));
      cand_valid = bit'($urandom_range(3) != 0);
      wb_int_en = bit'($urandom_range(1)); wb_int_reg = 5'($urandom_range(7));
      wb_long_en = bit'($urandom_range(3) == 0); wb_long_reg = 5'($urandom_range(7));
      flush = bit'($urandom_range(63) == 0);
      step("R2 R3 R4 R6 R7 R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule